// File: doc/BRIEF.md
# Byte-Port Multicycle CPU Sequencer

This block is the control core of a small 8-bit processor with four general registers. All traffic goes through one byte-wide memory port covering 2^AW bytes. The block fetches each 16-bit instruction as two byte reads, high byte first. It decodes the opcode, destination, source and immediate fields. For instructions that carry an absolute address, it fetches a second big-endian word. It then runs one execute step. That step performs arithmetic and logic writeback, a load, a store, an unconditional or conditional jump, a subroutine call with a two-byte stack push, or a halt.

A system instantiates it next to a byte memory whose read data follows the address within the same cycle. Programs get constants into registers only by loading them from memory, because there is no immediate-load instruction. The core holds the program counter, the instruction fields, the four registers, a four-bit flag set (zero, negative, carry, overflow) and the stack pointer. The arithmetic unit, the register file and the branch-condition selector are separate submodules.

Top module: `cpu8_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, PC is 0, SP is all ones (2^AW-1), registers and flags are 0, `halted` is 0 and `mem_wr` is 0. The first cycle after release strobes a read of address 0.
- R2: An instruction word is read in two consecutive cycles: the byte at PC supplies bits 15:8, then the byte at PC+1 supplies bits 7:0. Bits 15:12 are the opcode, 11:10 the destination register, 9:8 the source register and 7:0 the immediate.
- R3: Opcodes 0x0 to 0x9 take one execute cycle and advance PC by 2. The operations are: 0x0 add, 0x1 subtract, 0x2 and, 0x3 or, 0x4 xor, 0x5 shift the destination left by one, 0x6 shift it right by one, 0x7 multiply keeping the low 8 bits, 0x8 unsigned divide, 0x9 compare (subtract with no register write). Division by zero yields 0xFF.
- R4: Opcodes 0x0 to 0x9 set Z (result zero) and N (result bit 7). C is the add carry-out, the subtract/compare borrow, the bit shifted out, a nonzero multiply high byte, or 1 on division by zero, and 0 otherwise. V is signed overflow for add, subtract and compare, and 0 otherwise. Opcodes 0xA to 0xF leave the flags unchanged.
- R5: Opcodes 0xA to 0xE read an address word from PC+2 (high byte) and PC+3 (low byte) and use its low AW bits. When they do not jump, PC advances by 4.
- R6: Load (0xA) writes the byte at the address into the destination register. Store (0xB) writes the source register to the address.
- R7: Jump (0xC) sets PC to the address. Conditional jump (0xD) takes the address when the condition chosen by imm8[2:0] holds: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear. Only these three bits are decoded. If the jump is not taken, the next fetch is at PC+4.
- R8: Call (0xE) writes the low byte of the 16-bit zero-extended return address PC+4 to SP-1, then writes its high byte to SP-2 in the next cycle. It then decrements SP by 2 and jumps to the address.
- R9: Halt (0xF) raises `halted` permanently. After that the block issues no read or write strobe and no state changes.
- R10: All PC, SP and address arithmetic wraps modulo 2^AW.
- R11: `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The properties assume three things about the inputs. Memory read data follows the address combinationally within one cycle. Reset is released in step with the clock. Programs keep their code clear of the data and stack bytes they touch. The bench meets these assumptions in four ways. Its memory model answers reads from a plain array with no delay, and it releases reset on a falling clock edge. Random programs use only forward branches, jumps and calls, which guarantees termination. Data accesses and results go to fixed regions well away from both the code and the downward-growing stack. One directed program deliberately executes across the top of the address space so that the fetch wraps to address 0.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_SUB   = 4'h1,
    OP_AND   = 4'h2,
    OP_OR    = 4'h3,
    OP_XOR   = 4'h4,
    OP_SHL   = 4'h5,
    OP_SHR   = 4'h6,
    OP_MUL   = 4'h7,
    OP_DIV   = 4'h8,
    OP_CMP   = 4'h9,
    OP_LOAD  = 4'hA,
    OP_STORE = 4'hB,
    OP_JMP   = 4'hC,
    OP_JCC   = 4'hD,
    OP_CALL  = 4'hE,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FHI  = 3'd0,
    ST_FLO  = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_EXEC = 3'd4,
    ST_PUSH = 3'd5,
    ST_HALT = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  // Opcodes that carry a trailing absolute-address word.
  function automatic logic has_addr_word(input opcode_e op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_JMP) ||
           (op == OP_JCC)  || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output flags_t        flg,
  output logic          wr_en,
  output logic          flg_en
);

  localparam int unsigned PW = 2 * DW;

  logic [DW:0]   sum_w;
  logic [DW:0]   dif_w;
  logic [PW-1:0] prod_w;
  logic          b_zero;
  logic          carry;
  logic          ovf;

  assign sum_w  = {1'b0, a} + {1'b0, b};
  assign dif_w  = {1'b0, a} - {1'b0, b};
  assign prod_w = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
  assign b_zero = (b == '0);

  always_comb begin
    res    = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    wr_en  = 1'b1;
    flg_en = 1'b1;
    unique case (op)
      OP_ADD: begin
        res   = sum_w[DW-1:0];
        carry = sum_w[DW];
        ovf   = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
      end
      OP_SUB, OP_CMP: begin
        res   = dif_w[DW-1:0];
        carry = dif_w[DW];
        ovf   = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
        wr_en = (op == OP_SUB);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin
        res   = {a[DW-2:0], 1'b0};
        carry = a[DW-1];
      end
      OP_SHR: begin
        res   = {1'b0, a[DW-1:1]};
        carry = a[0];
      end
      OP_MUL: begin
        res   = prod_w[DW-1:0];
        carry = |prod_w[PW-1:DW];
      end
      OP_DIV: begin
        if (b_zero) begin
          res   = '1;
          carry = 1'b1;
        end else begin
          res = a / b;
        end
      end
      default: begin
        wr_en  = 1'b0;
        flg_en = 1'b0;
      end
    endcase
  end

  assign flg.z = (res == '0);
  assign flg.n = res[DW-1];
  assign flg.c = carry;
  assign flg.v = ovf;

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  output logic [DW-1:0]           rdata_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [DW-1:0]           rdata_b
);

  localparam int unsigned RAW = $clog2(NREG);
  localparam int unsigned FW  = DW * NREG;

  logic [FW-1:0] flat_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          en;
    assign en = we && (waddr == RAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wdata;
      end
    end
    assign flat_q[g*DW +: DW] = q;
  end

  assign rdata_a = flat_q[DW*raddr_a +: DW];
  assign rdata_b = flat_q[DW*raddr_b +: DW];

endmodule

// File: rtl/cpu8_cond.sv
module cpu8_cond
  import cpu8_pkg::*;
(
  input  flags_t     flags,
  input  logic [2:0] sel,
  output logic       take
);

  logic base;

  always_comb begin
    unique case (sel[2:1])
      2'd0:    base = flags.z;
      2'd1:    base = flags.c;
      2'd2:    base = flags.n;
      default: base = flags.v;
    endcase
  end

  // Odd selector values invert the chosen flag.
  assign take = base ^ sel[0];

endmodule

// File: rtl/cpu8_seq_ctrl.sv
module cpu8_seq_ctrl
  import cpu8_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted
);

  localparam int unsigned DW   = 8;
  localparam int unsigned NREG = 4;
  localparam int unsigned RAW  = $clog2(NREG);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, sp_q, sp_d, tgt_q, tgt_d;
  logic          pc_en, sp_en, tgt_en;
  logic [7:0]    iw_q;
  logic          iw_en;
  logic [2:0]    cc_q;
  logic          cc_en;
  flags_t        flags_q;
  logic          flags_en;

  logic [AW-1:0] pc_p1, pc_p2, pc_p3, pc_p4, sp_m1, sp_m2;
  logic [AW-1:0] tgt_from_hi, tgt_from_lo;
  logic [15:0]   ret_word;

  opcode_e        op;
  logic [RAW-1:0] rd_sel, rs_sel;
  logic [DW-1:0]  rd_val, rs_val;

  logic           rf_we;
  logic [DW-1:0]  rf_wd;

  logic [DW-1:0]  alu_res;
  flags_t         alu_flg;
  logic           alu_we, alu_fe;
  logic           jcc_take;

  assign op     = opcode_e'(iw_q[7:4]);
  assign rd_sel = iw_q[3:2];
  assign rs_sel = iw_q[1:0];

  assign pc_p1 = pc_q + AW'(1);
  assign pc_p2 = pc_q + AW'(2);
  assign pc_p3 = pc_q + AW'(3);
  assign pc_p4 = pc_q + AW'(4);
  assign sp_m1 = sp_q - AW'(1);
  assign sp_m2 = sp_q - AW'(2);

  assign ret_word = 16'(pc_p4);

  // Address-word capture: wide spaces keep bits from both bytes,
  // narrow spaces keep only the low byte's bits.
  if (AW > 8) begin : g_wide_addr
    assign tgt_from_hi = {mem_rdata[AW-9:0], tgt_q[7:0]};
    assign tgt_from_lo = {tgt_q[AW-1:8], mem_rdata};
  end else begin : g_narrow_addr
    assign tgt_from_hi = tgt_q;
    assign tgt_from_lo = mem_rdata[AW-1:0];
  end

  cpu8_regfile #(
    .DW   (DW),
    .NREG (NREG)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rd_sel),
    .wdata   (rf_wd),
    .raddr_a (rd_sel),
    .rdata_a (rd_val),
    .raddr_b (rs_sel),
    .rdata_b (rs_val)
  );

  cpu8_alu #(
    .DW (DW)
  ) u_alu (
    .op     (op),
    .a      (rd_val),
    .b      (rs_val),
    .res    (alu_res),
    .flg    (alu_flg),
    .wr_en  (alu_we),
    .flg_en (alu_fe)
  );

  cpu8_cond u_cond (
    .flags (flags_q),
    .sel   (cc_q),
    .take  (jcc_take)
  );

  // Next-state and memory-port decode
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    pc_en     = 1'b0;
    sp_d      = sp_q;
    sp_en     = 1'b0;
    tgt_d     = tgt_q;
    tgt_en    = 1'b0;
    iw_en     = 1'b0;
    cc_en     = 1'b0;
    flags_en  = 1'b0;
    rf_we     = 1'b0;
    rf_wd     = alu_res;
    mem_addr  = pc_q;
    mem_wdata = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;

    unique case (state_q)
      ST_FHI: begin
        mem_rd  = 1'b1;
        iw_en   = 1'b1;
        state_d = ST_FLO;
      end
      ST_FLO: begin
        mem_addr = pc_p1;
        mem_rd   = 1'b1;
        cc_en    = 1'b1;
        state_d  = has_addr_word(op) ? ST_AHI : ST_EXEC;
      end
      ST_AHI: begin
        mem_addr = pc_p2;
        mem_rd   = 1'b1;
        tgt_d    = tgt_from_hi;
        tgt_en   = 1'b1;
        state_d  = ST_ALO;
      end
      ST_ALO: begin
        mem_addr = pc_p3;
        mem_rd   = 1'b1;
        tgt_d    = tgt_from_lo;
        tgt_en   = 1'b1;
        state_d  = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FHI;
        unique case (op)
          OP_LOAD: begin
            mem_addr = tgt_q;
            mem_rd   = 1'b1;
            rf_we    = 1'b1;
            rf_wd    = mem_rdata;
            pc_d     = pc_p4;
            pc_en    = 1'b1;
          end
          OP_STORE: begin
            mem_addr  = tgt_q;
            mem_wr    = 1'b1;
            mem_wdata = rs_val;
            pc_d      = pc_p4;
            pc_en     = 1'b1;
          end
          OP_JMP: begin
            pc_d  = tgt_q;
            pc_en = 1'b1;
          end
          OP_JCC: begin
            pc_d  = jcc_take ? tgt_q : pc_p4;
            pc_en = 1'b1;
          end
          OP_CALL: begin
            mem_addr  = sp_m1;
            mem_wr    = 1'b1;
            mem_wdata = ret_word[7:0];
            state_d   = ST_PUSH;
          end
          OP_HALT: begin
            state_d = ST_HALT;
          end
          default: begin
            rf_we    = alu_we;
            flags_en = alu_fe;
            pc_d     = pc_p2;
            pc_en    = 1'b1;
          end
        endcase
      end
      ST_PUSH: begin
        mem_addr  = sp_m2;
        mem_wr    = 1'b1;
        mem_wdata = ret_word[15:8];
        sp_d      = sp_m2;
        sp_en     = 1'b1;
        pc_d      = tgt_q;
        pc_en     = 1'b1;
        state_d   = ST_FHI;
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: begin
        state_d = ST_FHI;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FHI;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '1;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iw_q <= '0;
    end else if (iw_en) begin
      iw_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= '0;
    end else if (cc_en) begin
      cc_q <= mem_rdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= alu_flg;
    end
  end

  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/cpu8_seq_ctrl_chk.sv
module cpu8_seq_ctrl_chk
  import cpu8_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          halted,
  input seq_state_e    state_q,
  input logic [AW-1:0] sp_q,
  input logic [7:0]    iw_q,
  input flags_t        flags_q
);

  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  // R2
  fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FHI) |=> (mem_rd && (mem_addr == AW'($past(mem_addr) + AW'(1)))));

  // R8
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |=> ((sp_q == AW'($past(sp_q) - AW'(2))) && (state_q == ST_FHI)));

  // R8
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |-> (mem_wr && (mem_addr == AW'($past(mem_addr) - AW'(1)))));

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EXEC) && (iw_q[7:4] >= 4'hA)) |=> (flags_q == $past(flags_q)));

endmodule

bind cpu8_seq_ctrl cpu8_seq_ctrl_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .halted   (halted),
  .state_q  (state_q),
  .sp_q     (sp_q),
  .iw_q     (iw_q),
  .flags_q  (flags_q)
);

// File: tb/cpu8_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu8_seq_ctrl_tb_top;

  localparam int AW  = 8;
  localparam int MSZ = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_rd, mem_wr, halted;

  logic [7:0] mem     [MSZ];
  logic [7:0] img     [MSZ];
  logic [7:0] ref_mem [MSZ];

  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = 8'h00;
  logic [7:0] ld_data = 8'h00;

  int n_chk = 0;
  int n_fail = 0;
  int excl_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cpu8_seq_ctrl #(.AW(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_rd === 1'b1 && mem_wr === 1'b1) excl_bad <= excl_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference arithmetic: {write, z, n, c, v, result}
  function automatic logic [12:0] ref_alu(input logic [3:0] op,
                                          input logic [7:0] a, input logic [7:0] b);
    logic [8:0]  w;
    logic [15:0] p;
    logic [7:0]  y;
    logic        c, v;
    y = 8'h00; c = 1'b0; v = 1'b0;
    case (op)
      4'h0: begin w = a + b; y = w[7:0]; c = w[8];
                  v = (a[7] == b[7]) && (y[7] != a[7]); end
      4'h1, 4'h9: begin y = a - b; c = (a < b);
                  v = (a[7] != b[7]) && (y[7] != a[7]); end
      4'h2: y = a & b;
      4'h3: y = a | b;
      4'h4: y = a ^ b;
      4'h5: begin y = {a[6:0], 1'b0}; c = a[7]; end
      4'h6: begin y = {1'b0, a[7:1]}; c = a[0]; end
      4'h7: begin p = a * b; y = p[7:0]; c = (p[15:8] != 8'h00); end
      default: begin
        if (b == 8'h00) begin y = 8'hFF; c = 1'b1; end
        else y = a / b;
      end
    endcase
    return {op != 4'h9, y == 8'h00, y[7], c, v, y};
  endfunction

  // Instruction-level model run on ref_mem
  task automatic run_ref();
    logic [7:0] pc, sp, ad, b0, b1;
    logic [7:0] r [4];
    logic       z, n, c, v, take, done;
    logic [12:0] ar;
    logic [3:0]  op;
    logic [1:0]  rd, rs;
    pc = 8'h00; sp = 8'hFF; z = 0; n = 0; c = 0; v = 0; done = 0;
    for (int i = 0; i < 4; i++) r[i] = 8'h00;
    for (int step = 0; step < 1000 && !done; step++) begin
      b0 = ref_mem[pc];
      b1 = ref_mem[8'(pc + 8'd1)];
      op = b0[7:4]; rd = b0[3:2]; rs = b0[1:0];
      ad = ref_mem[8'(pc + 8'd3)];
      if (op <= 4'h9) begin
        ar = ref_alu(op, r[rd], r[rs]);
        if (ar[12]) r[rd] = ar[7:0];
        {z, n, c, v} = ar[11:8];
        pc = 8'(pc + 8'd2);
      end else begin
        case (op)
          4'hA: begin r[rd] = ref_mem[ad]; pc = 8'(pc + 8'd4); end
          4'hB: begin ref_mem[ad] = r[rs]; pc = 8'(pc + 8'd4); end
          4'hC: pc = ad;
          4'hD: begin
            case (b1[2:0])
              3'd0: take = z;   3'd1: take = !z;
              3'd2: take = c;   3'd3: take = !c;
              3'd4: take = n;   3'd5: take = !n;
              3'd6: take = v;   default: take = !v;
            endcase
            pc = take ? ad : 8'(pc + 8'd4);
          end
          4'hE: begin
            ref_mem[8'(sp - 8'd1)] = 8'(pc + 8'd4);
            ref_mem[8'(sp - 8'd2)] = 8'h00;
            sp = 8'(sp - 8'd2);
            pc = ad;
          end
          default: done = 1;
        endcase
      end
    end
  endtask

  task automatic load_image();
    rst_n = 1'b0;
    for (int a = 0; a < MSZ; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = img[a];
      ref_mem[a] = img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic finish_prog(input string tag);
    int lim, bad, first;
    bit quiet;
    lim = 0;
    while (halted !== 1'b1 && lim < 4000) begin
      @(negedge clk);
      lim++;
    end
    chk(halted === 1'b1, "R9", {tag, " halt reached"}, int'(halted), 1);
    quiet = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (mem_rd !== 1'b0 || mem_wr !== 1'b0 || halted !== 1'b1) quiet = 0;
    end
    chk(quiet, "R9", {tag, " quiet after halt"}, int'(quiet), 1);
    run_ref();
    bad = 0; first = -1;
    for (int a = 0; a < MSZ; a++) begin
      if (mem[a] !== ref_mem[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) first = 0;
    chk(bad == 0, "R3 R6 R7", {tag, " final memory vs model"},
        int'(mem[first]), int'(ref_mem[first]));
  endtask

  task automatic trace(input string req, input bit exp_rd, input int exp_addr);
    chk(mem_rd === exp_rd, req, "read strobe", int'(mem_rd), int'(exp_rd));
    if (exp_rd) chk(mem_addr === 8'(exp_addr), req, "fetch address",
                    int'(mem_addr), exp_addr);
  endtask

  task automatic put4(input int at, input logic [7:0] a0, input logic [7:0] a1,
                      input logic [7:0] a2, input logic [7:0] a3);
    img[at] = a0; img[at+1] = a1; img[at+2] = a2; img[at+3] = a3;
  endtask

  task automatic gen_random();
    int        nins, estart, j;
    int        starts [33];
    logic [3:0] ops   [32];
    logic [7:0] b0, ah;
    for (int a = 0; a < MSZ; a++) img[a] = 8'h00;
    for (int a = 8'hA0; a < 8'hC0; a++) img[a] = 8'($urandom);
    nins = 8 + int'($urandom % 17);
    starts[0] = 0;
    for (int i = 0; i < nins; i++) begin
      ops[i] = 4'($urandom % 15);
      starts[i+1] = starts[i] + ((ops[i] >= 4'hA) ? 4 : 2);
    end
    estart = starts[nins];
    for (int i = 0; i < nins; i++) begin
      b0 = {ops[i], 4'($urandom)};
      img[starts[i]]     = b0;
      img[starts[i] + 1] = 8'($urandom);
      if (ops[i] >= 4'hA) begin
        ah = 8'($urandom);
        img[starts[i] + 2] = ah;
        if (ops[i] <= 4'hB) img[starts[i] + 3] = 8'(8'hA0 + ($urandom % 32));
        else begin
          j = i + 1 + int'($urandom % (nins - i));
          img[starts[i] + 3] = 8'(starts[j]);
        end
      end
    end
    for (int k = 0; k < 4; k++)
      put4(estart + 4*k, {4'hB, 2'b00, 2'(k)}, 8'h00, 8'h00, 8'(8'hC0 + k));
    img[estart + 16] = 8'hF0;
    img[estart + 17] = 8'h00;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0;

    // Directed 1: untaken branch, wrap of the fetch past the top address
    for (int a = 0; a < MSZ; a++) img[a] = 8'h00;
    put4(8'h00, 8'hD0, 8'h02, 8'h00, 8'h10);  // branch if C set -> 0x10
    put4(8'h04, 8'hA4, 8'h00, 8'h00, 8'h80);  // R1 <- [0x80]
    put4(8'h08, 8'hC0, 8'h00, 8'h00, 8'hFE);  // jump 0xFE
    img[8'hFE] = 8'h05; img[8'hFF] = 8'h00;   // R1 = R1 + R1
    put4(8'h10, 8'hB1, 8'h00, 8'h00, 8'h81);  // [0x81] <- R1
    img[8'h14] = 8'hF0;
    img[8'h80] = 8'hFF;
    load_image();
    chk(halted === 1'b0, "R1", "halted in reset", int'(halted), 0);
    chk(mem_wr === 1'b0, "R1", "write strobe in reset", int'(mem_wr), 0);
    rst_n = 1'b1;
    #1;
    trace("R1", 1'b1, 0);
    @(negedge clk); trace("R2", 1'b1, 1);
    @(negedge clk); trace("R5", 1'b1, 2);
    @(negedge clk); trace("R5", 1'b1, 3);
    @(negedge clk); trace("R7", 1'b0, 0);
    @(negedge clk); trace("R7", 1'b1, 4);
    finish_prog("wrap");
    chk(mem[8'h81] === 8'hFE, "R10", "sum stored after wrapped fetch",
        int'(mem[8'h81]), 8'hFE);

    // Directed 2: nested calls push return addresses
    for (int a = 0; a < MSZ; a++) img[a] = 8'h00;
    put4(8'h00, 8'hE0, 8'h00, 8'h00, 8'h20);
    put4(8'h20, 8'hE0, 8'h00, 8'h00, 8'h30);
    img[8'h30] = 8'hF0;
    load_image();
    rst_n = 1'b1;
    finish_prog("call");
    chk(mem[8'hFE] === 8'h04, "R8", "first push low", int'(mem[8'hFE]), 8'h04);
    chk(mem[8'hFD] === 8'h00, "R8", "first push high", int'(mem[8'hFD]), 8'h00);
    chk(mem[8'hFC] === 8'h24, "R8", "second push low", int'(mem[8'hFC]), 8'h24);
    chk(mem[8'hFB] === 8'h00, "R8", "second push high", int'(mem[8'hFB]), 8'h00);

    // Directed 3: divide by zero, compare without writeback, shift carry
    for (int a = 0; a < MSZ; a++) img[a] = 8'h00;
    put4(8'h00, 8'hA0, 8'h00, 8'h00, 8'h80);
    put4(8'h04, 8'hA4, 8'h00, 8'h00, 8'h81);
    img[8'h08] = 8'h81; img[8'h09] = 8'h00;   // R0 = R0 / R1
    put4(8'h0A, 8'hB0, 8'h00, 8'h00, 8'h90);
    img[8'h0E] = 8'h90; img[8'h0F] = 8'h00;   // compare R0, R0
    put4(8'h10, 8'hD0, 8'hF8, 8'h00, 8'h18);  // Z set -> 0x18 (upper imm bits set)
    img[8'h14] = 8'hF0;
    put4(8'h18, 8'hB0, 8'h00, 8'h00, 8'h91);
    img[8'h1C] = 8'h50; img[8'h1D] = 8'h00;   // shift R0 left
    put4(8'h1E, 8'hB0, 8'h00, 8'h00, 8'h92);
    img[8'h22] = 8'hF0;
    img[8'h80] = 8'h80; img[8'h81] = 8'h00;
    load_image();
    rst_n = 1'b1;
    finish_prog("alu");
    chk(mem[8'h90] === 8'hFF, "R3", "divide by zero", int'(mem[8'h90]), 8'hFF);
    chk(mem[8'h91] === 8'hFF, "R7", "compare keeps R0, branch taken",
        int'(mem[8'h91]), 8'hFF);
    chk(mem[8'h92] === 8'hFE, "R4", "shift left result", int'(mem[8'h92]), 8'hFE);

    // Random programs with forward-only control flow
    for (int p = 0; p < 36; p++) begin
      gen_random();
      load_image();
      rst_n = 1'b1;
      finish_prog($sformatf("rand%0d", p));
    end

    chk(excl_bad == 0, "R11", "read and write in same cycle", excl_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule